// File: doc/BRIEF.md
# Second-Order Pulse-Density Decimator

This block turns a one-bit pulse-density stream into multi-bit samples with a second-order cascaded integrator-comb filter. It accumulates every input bit through two wrap-around integrators, takes a snapshot of the second one at the end of each decimation period and differences the snapshots twice. The result is the number of ones in the stream, weighted by a triangle that spans two periods.

A configuration word sets the filter mode and a power-of-two period. A separate select input picks where the sample ticks come from. Either every system clock is a tick, for a modulator beside the block, or each rising edge of an external bit clock is a tick, for a modulator off-chip. The external clock and its data line are synchronized into the system clock domain first.

Settings the hardware cannot honour raise a flag and suppress all output strobes. Any change of configuration restarts the period and drops the first samples while the comb stages refill.

Top module: `pdm_sinc2_decim`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `sample_vld_o` is 0, `cfg_bad_o` is 0 and `sample_o` is 0.
- R2: With `ext_sel_i`=0 every system clock is a tick. Once the output has settled, `sample_vld_o` pulses once every 2^N clocks, where N = `cfg_i[3:0]`.
- R3: A valid sample equals the sum of the last 2·2^N input bits, weighted as follows. Take index i = 0 for the newest bit. The weight is i+1 for i < 2^N and 2·2^N−1−i for larger i. A stream of all ones therefore gives 4^N and a stream of all zeros gives 0.
- R4: Both integrators are 27 bits wide and wrap modulo 2^27. Samples stay correct after the integrators wrap, and a valid sample never exceeds 4^N.
- R5: When the mode field `cfg_i[5:4]` is not 00, `cfg_bad_o` is 1 from the cycle after the setting is applied, and `sample_vld_o` stays 0.
- R6: When N is greater than 13, `cfg_bad_o` is 1 and `sample_vld_o` stays 0. N = 13, a period of 8192 ticks, is accepted, and an all-ones stream at that setting gives 2^26.
- R7: A change of `cfg_i` or `ext_sel_i` restarts the period counter and drops the next two period results. Suppose the change is first seen at clock edge e0 and ticks are internal. Then the first strobe appears after edge e(3·2^N), which is the 3·2^N+1-th edge counted from e0 inclusive.
- R8: With `ext_sel_i`=1, `bit_clk_i` and `pdm_i` each pass through two flip-flops. One tick occurs per synchronized rising edge of the bit clock, and it uses the synchronized data bit. With the bit clock held still there are no ticks and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 6 | [5:4] mode (00 = sinc2), [3:0] log2 of the period N |
| ext_sel_i | input | 1 | 1: ticks from external bit clock, 0: one tick per system clock |
| bit_clk_i | input | 1 | External bit clock, asynchronous |
| pdm_i | input | 1 | Pulse-density data bit |
| sample_o | output | 27 | Last valid decimated sample, unsigned |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |
| cfg_bad_o | output | 1 | Current configuration is unsupported |

## Verification
The assertions assume the following about the external bit clock:
- it stays high and low for at least two system clocks, so the edge detector sees each edge once;
- the data line is stable whenever the synchronized clock edge arrives.

The bench meets these assumptions by dividing the system clock by eight to make the bit clock, and by changing the data bit only on the falling edge of that clock. The configuration may change in any cycle. The bench changes it only between phases and always on the falling system-clock edge, so the reference model sees the same change cycle as the design.

// File: rtl/pdm_sinc2_pkg.sv
package pdm_sinc2_pkg;
  localparam int unsigned ACC_W    = 27;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned LOG2_W   = 4;
  localparam int unsigned LOG2_MAX = 13;
  localparam int unsigned CNT_W    = 1 << LOG2_W;

  typedef struct packed {
    logic              ext;
    logic [MODE_W-1:0] mode;
    logic [LOG2_W-1:0] log2;
  } dec_cfg_t;

  // unsupported: any mode but sinc2, or a period beyond the register budget
  function automatic logic cfg_unsupported(input dec_cfg_t c);
    return (c.mode != '0) || (int'(c.log2) > int'(LOG2_MAX));
  endfunction

  // terminal count of the period counter for 2^n ticks
  function automatic logic [CNT_W-1:0] period_last(input logic [LOG2_W-1:0] n);
    return (CNT_W'(1) << n) - CNT_W'(1);
  endfunction

  // largest value a valid sample may take: (2^n)^2
  function automatic logic [ACC_W-1:0] sample_ceiling(input logic [LOG2_W-1:0] n);
    return ACC_W'(1) << (2 * int'(n));
  endfunction
endpackage

// File: rtl/pdm_tick_src.sv
module pdm_tick_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sel_i,
  input  logic bit_clk_i,
  input  logic pdm_i,
  output logic tick_o,
  output logic bit_o
);
  // one extra stage on the clock chain keeps the previous synchronized level
  logic [SYNC_STAGES:0]   clk_sh;
  logic [SYNC_STAGES-1:0] dat_sh;
  logic                   ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sh <= '0;
      dat_sh <= '0;
    end else begin
      clk_sh <= (clk_sh << 1) | (SYNC_STAGES+1)'(bit_clk_i);
      dat_sh <= (dat_sh << 1) | SYNC_STAGES'(pdm_i);
    end
  end

  assign ext_tick = clk_sh[SYNC_STAGES-1] & ~clk_sh[SYNC_STAGES];
  assign tick_o   = ext_sel_i ? ext_tick : 1'b1;
  assign bit_o    = ext_sel_i ? dat_sh[SYNC_STAGES-1] : pdm_i;

  // an edge-detected tick can never last two cycles
  assert_tick_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_tick |=> !ext_tick);
endmodule

// File: rtl/pdm_period_ctr.sv
module pdm_period_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             boundary_o
);
  logic [CNT_W-1:0] cnt_q;

  assign boundary_o = tick_i & ~restart_i & (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= boundary_o ? '0 : cnt_q + CNT_W'(1);
  end

  // the terminal count from the configuration register bounds the counter
  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/sinc2_integ.sv
module sinc2_integ #(
  parameter int unsigned ACC_W = 27,
  parameter int unsigned ORDER = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_next_o
);
  logic [ACC_W-1:0] acc_q [ORDER];
  logic [ACC_W-1:0] acc_d [ORDER];
  logic [ACC_W-1:0] carry;

  // each stage adds the updated value of the stage before it, modulo 2^ACC_W
  always_comb begin
    carry = ACC_W'(bit_i);
    for (int k = 0; k < ORDER; k++) begin
      acc_d[k] = acc_q[k] + carry;
      carry    = acc_d[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++) acc_q[k] <= '0;
    end else if (tick_i) begin
      for (int k = 0; k < ORDER; k++) acc_q[k] <= acc_d[k];
    end
  end

  assign acc_next_o = acc_d[ORDER-1];

  // the first integrator moves by zero or one per cycle, wrapping at 2^ACC_W
  assert_integ_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (acc_q[0] == $past(acc_q[0])) || (acc_q[0] == $past(acc_q[0]) + ACC_W'(1)));
endmodule

// File: rtl/sinc2_comb.sv
module sinc2_comb #(
  parameter int unsigned ACC_W = 27,
  parameter int unsigned ORDER = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic             restart_i,
  input  logic             allow_i,
  input  logic [ACC_W-1:0] snap_i,
  output logic [ACC_W-1:0] sample_o,
  output logic             vld_o
);
  localparam int unsigned DISC_W = $clog2(ORDER + 1);

  logic [ACC_W-1:0]  prev_q [ORDER];
  logic [ACC_W-1:0]  stage_in [ORDER];
  logic [ACC_W-1:0]  dif [ORDER];
  logic [ACC_W-1:0]  carry;
  logic [DISC_W-1:0] disc_q;
  logic              emit;

  always_comb begin
    carry = snap_i;
    for (int k = 0; k < ORDER; k++) begin
      stage_in[k] = carry;
      dif[k]      = carry - prev_q[k];
      carry       = dif[k];
    end
  end

  assign emit = boundary_i & (disc_q == '0) & allow_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++) prev_q[k] <= '0;
      disc_q   <= DISC_W'(ORDER);
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= emit;
      if (emit) sample_o <= dif[ORDER-1];
      if (restart_i) begin
        disc_q <= DISC_W'(ORDER);
      end else if (boundary_i) begin
        for (int k = 0; k < ORDER; k++) prev_q[k] <= stage_in[k];
        if (disc_q != '0) disc_q <= disc_q - DISC_W'(1);
      end
    end
  end

  // a restart always precedes at least ORDER suppressed boundaries
  assert_settle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !vld_o);
endmodule

// File: rtl/pdm_sinc2_decim.sv
module pdm_sinc2_decim
  import pdm_sinc2_pkg::*;
#(
  parameter int unsigned ACC_BITS    = pdm_sinc2_pkg::ACC_W,
  parameter int unsigned ORDER       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [5:0]          cfg_i,
  input  logic                ext_sel_i,
  input  logic                bit_clk_i,
  input  logic                pdm_i,
  output logic [ACC_BITS-1:0] sample_o,
  output logic                sample_vld_o,
  output logic                cfg_bad_o
);
  dec_cfg_t            cfg_now, cfg_q;
  logic                cfg_chg;
  logic                tick, tick_bit, boundary, allow;
  logic [ACC_BITS-1:0] snap;

  assign cfg_now = '{ext: ext_sel_i, mode: cfg_i[5:4], log2: cfg_i[3:0]};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_now;
  end

  assign cfg_bad_o = cfg_unsupported(cfg_q);
  assign allow     = ~cfg_bad_o;

  pdm_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .ext_sel_i, .bit_clk_i, .pdm_i,
    .tick_o(tick), .bit_o(tick_bit));

  pdm_period_ctr #(.CNT_W(CNT_W)) u_period (
    .clk_i, .rst_ni, .tick_i(tick), .restart_i(cfg_chg),
    .last_i(period_last(cfg_q.log2)), .boundary_o(boundary));

  sinc2_integ #(.ACC_W(ACC_BITS), .ORDER(ORDER)) u_integ (
    .clk_i, .rst_ni, .tick_i(tick), .bit_i(tick_bit), .acc_next_o(snap));

  sinc2_comb #(.ACC_W(ACC_BITS), .ORDER(ORDER)) u_comb (
    .clk_i, .rst_ni, .boundary_i(boundary), .restart_i(cfg_chg), .allow_i(allow),
    .snap_i(snap), .sample_o(sample_o), .vld_o(sample_vld_o));

  // a strobe only ever leaves under a supported configuration
  assert_no_strobe_when_bad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> !cfg_bad_o);
  // a settled second-order result is bounded by the square of the period
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> (sample_o <= ACC_BITS'(sample_ceiling(cfg_q.log2))));
  // the period stays within the hardware limit whenever a strobe is emitted
  assert_period_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> (int'(cfg_q.log2) <= int'(LOG2_MAX)));
endmodule

// File: tb/pdm_sinc2_decim_tb_top.sv
module pdm_sinc2_decim_tb_top;
  localparam longint MASK = (64'd1 << 27) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg = 6'd0;
  logic        ext_sel = 1'b0;
  logic        bclk = 1'b0;
  logic        pdm = 1'b0;
  logic [26:0] sample;
  logic        vld, bad;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pdm_sinc2_decim dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .ext_sel_i(ext_sel),
    .bit_clk_i(bclk), .pdm_i(pdm), .sample_o(sample),
    .sample_vld_o(vld), .cfg_bad_o(bad));

  // stimulus patterns: 0 zeros, 1 ones, 2 alternating, 3 pseudo-random
  int       pat = 0;
  logic     bclk_run = 1'b0;
  int       div = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic next_bit(input int p, input logic cur, input logic [15:0] l);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return ~cur;
      default: return l[0];
    endcase
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!ext_sel) pdm <= next_bit(pat, pdm, lfsr);
    if (bclk_run) begin
      div <= (div + 1) % 4;
      if (div == 3) begin
        bclk <= ~bclk;
        if (bclk) pdm <= next_bit(pat, pdm, lfsr);
      end
    end
  end

  // behavioural reference: bit history and triangle-weighted sums
  bit     hist[$];
  logic [2:0] m_csh;
  logic [1:0] m_dsh;
  logic [6:0] m_cfg;
  int     m_cnt, m_disc;
  logic   e_vld, e_bad;
  longint e_sample;

  function automatic logic m_bad(input logic [6:0] c);
    return (c[5:4] != 2'b00) || (c[3:0] > 4'd13);
  endfunction

  function automatic longint tri_sum(input int n);
    longint s = 0;
    int p = 1 << n;
    for (int i = 0; i < 2 * p && i < hist.size(); i++)
      if (hist[i]) s += (i < p) ? (i + 1) : (2 * p - 1 - i);
    return s & MASK;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_csh = '0; m_dsh = '0; m_cfg = '0; m_cnt = 0; m_disc = 2;
      e_vld = 1'b0; e_bad = 1'b0; e_sample = 0;
    end else begin
      logic tk, b;
      logic [6:0] now_c;
      tk = ext_sel ? (m_csh[1] & ~m_csh[2]) : 1'b1;
      b  = ext_sel ? m_dsh[1] : pdm;
      m_csh = {m_csh[1:0], bclk};
      m_dsh = {m_dsh[0], pdm};
      now_c = {ext_sel, cfg};
      e_vld = 1'b0;
      if (tk) begin
        hist.push_front(b);
        if (hist.size() > 20000) void'(hist.pop_back());
      end
      if (now_c != m_cfg) begin
        m_cfg = now_c; m_cnt = 0; m_disc = 2;
      end else if (tk) begin
        m_cnt++;
        if (m_cnt == (1 << m_cfg[3:0])) begin
          m_cnt = 0;
          if (m_disc == 0 && !m_bad(m_cfg)) begin
            e_vld = 1'b1;
            e_sample = tri_sum(int'(m_cfg[3:0]));
          end
          if (m_disc > 0) m_disc--;
        end
      end
      e_bad = m_bad(m_cfg);
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "sample_vld_o", longint'(vld), longint'(e_vld));
      check(cur_req, "cfg_bad_o", longint'(bad), longint'(e_bad));
      if (e_vld) check(cur_req, "sample_o", longint'(sample), e_sample);
    end
  end

  task automatic wait_vld(input int limit);
    int n = 0;
    do begin @(negedge clk); n++; end while (!vld && n < limit);
  endtask

  task automatic count_vld(input int cycles, output int cnt);
    cnt = 0;
    repeat (cycles) begin @(negedge clk); if (vld) cnt++; end
  endtask

  task automatic run_all();
    int n, cnt;
    @(negedge clk);
    check("R1", "vld in reset", longint'(vld), 0);
    check("R1", "bad in reset", longint'(bad), 0);
    check("R1", "sample in reset", longint'(sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "vld after reset", longint'(vld), 0);
    check("R1", "sample after reset", longint'(sample), 0);

    // R7: latency after a change, N=2, all ones
    cur_req = "R7"; pat = 1;
    cfg = 6'd2; n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!vld && n < 100);
    check("R7", "edges to first strobe", n, 13);
    check("R3", "all ones N=2", longint'(sample), 16);

    // R2: steady cadence of 4 clocks
    cur_req = "R2";
    count_vld(40, cnt);
    check("R2", "strobes in 40 clocks N=2", cnt, 10);

    // R3: zeros, alternating, random
    cur_req = "R3"; pat = 0;
    repeat (3) wait_vld(20);
    check("R3", "all zeros N=2", longint'(sample), 0);
    pat = 2; cfg = 6'd3; repeat (60) @(negedge clk);
    pat = 3; cfg = 6'd5; repeat (400) @(negedge clk);
    cfg = 6'd0; repeat (40) @(negedge clk);

    // R5: non-sinc2 mode
    cur_req = "R5"; cfg = 6'b01_0010;
    @(negedge clk); @(negedge clk);
    check("R5", "bad flag for mode 01", longint'(bad), 1);
    count_vld(100, cnt);
    check("R5", "no strobes for mode 01", cnt, 0);

    // R6: N=14 rejected over three full periods
    cur_req = "R6"; cfg = 6'd14;
    @(negedge clk); @(negedge clk);
    check("R6", "bad flag for N=14", longint'(bad), 1);
    count_vld(3 * 16384 + 20, cnt);
    check("R6", "no strobes for N=14", cnt, 0);

    // R6 and R4: N=13 accepted, integrators wrap
    cur_req = "R4"; pat = 1; cfg = 6'd13;
    @(negedge clk); @(negedge clk);
    check("R6", "N=13 accepted", longint'(bad), 0);
    wait_vld(30000);
    check("R6", "all ones N=13", longint'(sample), 64'd1 << 26);
    wait_vld(9000);
    check("R4", "after wrap N=13", longint'(sample), 64'd1 << 26);
    pat = 3; cfg = 6'd4; repeat (300) @(negedge clk);

    // R8: external bit clock
    cur_req = "R8"; ext_sel = 1'b1; cfg = 6'd3;
    count_vld(200, cnt);
    check("R8", "no strobes without bit clock", cnt, 0);
    bclk_run = 1'b1; pat = 1;
    count_vld(400, cnt);
    check("R8", "strobes with bit clock", longint'(cnt >= 3), 1);
    pat = 2; repeat (300) @(negedge clk);
    pat = 3; repeat (600) @(negedge clk);
    bclk_run = 1'b0; ext_sel = 1'b0;
    cur_req = "R2"; cfg = 6'd1; pat = 3;
    repeat (50) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog run did not complete");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule